// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block chooses which interrupt request is acknowledged next and keeps track of how deeply service routines are nested. There are sixteen maskable sources. Each source has a two-bit priority level, where 0 is the most urgent and 3 the least. Each source also has a fixed rank given by its index, and this rank settles ties between equal levels. Two more request classes sit beside the maskable ones. A non-maskable request can interrupt any maskable routine. A macro-service request is handed to a transfer engine without a context switch, so it never changes the nesting record.

A maskable request is granted only when two conditions hold. The global enable flag must be set; an enable pulse sets it, and every maskable grant clears it. The request must also be more urgent than the routine now in service. When a grant is made, the level being preempted is pushed onto a small stack. An end-of-service pulse pops that level back. Requests that are blocked stay pending until the conditions allow them.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset the block makes no acknowledge, the in-service code is 7 (idle), and the enable flag is clear.
- R2: A maskable request is acknowledged only while the enable flag is set. An enable pulse sets the flag, and every maskable acknowledge clears it.
- R3: A maskable grant raises the acknowledge pulse for one cycle, one clock after the pending state permits it. The pulse carries kind 0, the source index and its level. After the grant, the in-service code equals that level.
- R4: Outside the level-3 case of R6, a maskable request preempts the current routine only when its level number is strictly lower than the in-service level. The idle code 7 admits every level.
- R5: While a level-0 routine is in service, no maskable request is acknowledged, including another level-0 request. Such requests stay pending.
- R6: When the lock input is 1, a level-3 request cannot nest under level-3 service. When the lock input is 0, it can.
- R7: Among pending maskable requests that share the best level, the lowest source index is acknowledged first, whatever order the requests arrived in.
- R8: A macro-service request (acknowledge kind 1) is acknowledged whatever the enable flag, the in-service level and the other pending requests are. It leaves the in-service code unchanged and reports level 0.
- R9: A non-maskable request (acknowledge kind 2, source 0, level 0) is acknowledged during any maskable service, including level 0. It sets the in-service code to 4 and cannot nest under another non-maskable routine. If both are ready, it wins over macro-service and maskable requests.
- R10: An end-of-service pulse restores the previous in-service code from the stack, and no grant is made in that cycle. Requests held pending are then granted by level first and by index second.
- R11: The nesting stack holds six entries. While it is full, no maskable or non-maskable request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Maskable request pulses, one bit per source |
| lvl_i | input | 32 | Level of each source; source i uses bits [2i+1:2i] |
| macro_i | input | 16 | Macro-service request pulses, one bit per source |
| nmi_i | input | 1 | Non-maskable request pulse |
| ei_i | input | 1 | Pulse that sets the enable flag |
| lock3_i | input | 1 | 1 blocks level-3 nesting under level 3 |
| eos_i | input | 1 | End-of-service pulse |
| ack_valid_o | output | 1 | One-cycle acknowledge pulse |
| ack_kind_o | output | 2 | 0 maskable, 1 macro-service, 2 non-maskable |
| ack_src_o | output | 4 | Acknowledged source index |
| ack_lvl_o | output | 2 | Level of the acknowledged maskable source |
| svc_lvl_o | output | 3 | In-service code: 0 to 3 level, 4 non-maskable, 7 idle |

## Verification
The assertions check several things on every cycle. A maskable acknowledge always leaves the enable flag clear and the in-service code equal to the granted level. Such an acknowledge never happens under level-0 service, and it is always strictly more urgent than the routine it preempts, apart from the level-3 case that the lock input permits. Macro-service grants never move the in-service code, and the stack pointer stays in bounds. Other properties need a sequence of events and are shown only by the bench scenarios. These are the order in which pending requests are released after end-of-service, the rule that the lowest index wins among equal levels regardless of arrival, the withholding of grants while the stack is full, and the preference for a non-maskable request over a waiting maskable one.

// File: rtl/nia_pkg.sv
package nia_pkg;
  localparam logic [2:0] SVC_IDLE = 3'd7;
  localparam logic [2:0] SVC_NMI  = 3'd4;
  localparam int         SVC_W    = 3;

  typedef enum logic [1:0] {
    ACK_MASK  = 2'd0,
    ACK_MACRO = 2'd1,
    ACK_NMI   = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/nia_pending.sv
module nia_pending #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_d;
  logic [N-1:0] pend_q;

  // Per-source sticky bit; a new request wins over a same-cycle clear.
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nia_pick.sv
module nia_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [2*N-1:0]   lvl_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       lvl_o
);
  logic [2:0] best;

  // Scan from the highest index down; "<=" lets a lower index take a tie.
  always_comb begin
    best  = 3'd4;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && ({1'b0, lvl_i[2*i +: 2]} <= best)) begin
        best  = {1'b0, lvl_i[2*i +: 2]};
        idx_o = IDX_W'(i);
      end
    end
    found_o = (best != 3'd4);
    lvl_o   = best[1:0];
  end
endmodule

// File: rtl/nia_stack.sv
module nia_stack #(
  parameter int DEPTH = 6,
  parameter int W     = 3,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = push_i | pop_i;
    ptr_d  = ptr_q;
    if (push_i)     ptr_d = ptr_q + 1'b1;
    else if (pop_i) ptr_d = ptr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[ptr_q] <= din_i;
  end

  assign full_o  = (ptr_q == PTR_W'(DEPTH));
  assign empty_o = (ptr_q == '0);
  assign top_o   = empty_o ? '0 : mem_q[ptr_q - 1'b1];

  p_ptr_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(DEPTH));
  p_no_push_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import nia_pkg::*;
#(
  parameter int N     = 16,
  parameter int DEPTH = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic [2*N-1:0]   lvl_i,
  input  logic [N-1:0]     macro_i,
  input  logic             nmi_i,
  input  logic             ei_i,
  input  logic             lock3_i,
  input  logic             eos_i,
  output logic             ack_valid_o,
  output logic [1:0]       ack_kind_o,
  output logic [IDX_W-1:0] ack_src_o,
  output logic [1:0]       ack_lvl_o,
  output logic [SVC_W-1:0] svc_lvl_o
);
  logic [N-1:0]     msk_pend, mac_pend, msk_clr, mac_clr;
  logic             sel_found, mac_found;
  logic [IDX_W-1:0] sel_idx, mac_idx;
  logic [1:0]       sel_lvl, mac_lvl;
  logic             stk_full, stk_empty, stk_push, stk_pop;
  logic [SVC_W-1:0] stk_top;

  logic             ie_q, ie_d, nmi_q, nmi_d;
  logic [SVC_W-1:0] svc_q, svc_d;
  logic             svc_en;
  logic             nmi_go, mac_go, msk_go, lvl_ok;
  logic             ackv_d;
  logic [1:0]       kind_d, alvl_d;
  logic [IDX_W-1:0] src_d;

  nia_pending #(.N(N)) u_msk_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req_i), .clr_i(msk_clr), .pend_o(msk_pend));
  nia_pending #(.N(N)) u_mac_pend (
    .clk(clk), .rst_n(rst_n), .set_i(macro_i), .clr_i(mac_clr), .pend_o(mac_pend));

  nia_pick #(.N(N), .IDX_W(IDX_W)) u_msk_pick (
    .pend_i(msk_pend), .lvl_i(lvl_i),
    .found_o(sel_found), .idx_o(sel_idx), .lvl_o(sel_lvl));
  // Macro requests ignore levels: all-zero levels reduce the pick to index order.
  nia_pick #(.N(N), .IDX_W(IDX_W)) u_mac_pick (
    .pend_i(mac_pend), .lvl_i('0),
    .found_o(mac_found), .idx_o(mac_idx), .lvl_o(mac_lvl));

  nia_stack #(.DEPTH(DEPTH), .W(SVC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(stk_push), .pop_i(stk_pop),
    .din_i(svc_q), .top_o(stk_top), .full_o(stk_full), .empty_o(stk_empty));

  // Grant decision: NMI first, then macro service, then maskable.
  always_comb begin
    lvl_ok = (svc_q == SVC_IDLE) ||
             ((svc_q < SVC_NMI) &&
              (({1'b0, sel_lvl} < svc_q) ||
               (sel_lvl == 2'd3 && svc_q == 3'd3 && !lock3_i)));
    nmi_go = nmi_q && (svc_q != SVC_NMI) && !stk_full && !eos_i;
    mac_go = !nmi_go && mac_found && !eos_i;
    msk_go = !nmi_go && !mac_go && ie_q && sel_found && lvl_ok &&
             !stk_full && !eos_i;
  end

  always_comb begin
    stk_push = nmi_go | msk_go;
    stk_pop  = eos_i & ~stk_empty;
    msk_clr  = msk_go ? (N'(1) << sel_idx) : '0;
    mac_clr  = mac_go ? (N'(1) << mac_idx) : '0;
    nmi_d    = nmi_i | (nmi_q & ~nmi_go);
    ie_d     = msk_go ? 1'b0 : (ei_i ? 1'b1 : ie_q);
    svc_en   = eos_i | stk_push;
    svc_d    = svc_q;
    if (eos_i)       svc_d = stk_empty ? SVC_IDLE : stk_top;
    else if (nmi_go) svc_d = SVC_NMI;
    else if (msk_go) svc_d = {1'b0, sel_lvl};
    ackv_d = nmi_go | mac_go | msk_go;
    kind_d = nmi_go ? ACK_NMI : (mac_go ? ACK_MACRO : ACK_MASK);
    src_d  = nmi_go ? '0 : (mac_go ? mac_idx : sel_idx);
    alvl_d = (msk_go && !mac_go) ? sel_lvl : mac_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= 1'b0;
      nmi_q       <= 1'b0;
      svc_q       <= SVC_IDLE;
      ack_valid_o <= 1'b0;
      ack_kind_o  <= ACK_MASK;
      ack_src_o   <= '0;
      ack_lvl_o   <= '0;
    end else begin
      ie_q        <= ie_d;
      nmi_q       <= nmi_d;
      if (svc_en) svc_q <= svc_d;
      ack_valid_o <= ackv_d;
      if (ackv_d) begin
        ack_kind_o <= kind_d;
        ack_src_o  <= src_d;
        ack_lvl_o  <= alvl_d;
      end
    end
  end

  assign svc_lvl_o = svc_q;

  p_mask_clears_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_kind_o == ACK_MASK) |-> !ie_q);
  p_mask_records_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_kind_o == ACK_MASK) |-> svc_q == {1'b0, ack_lvl_o});
  p_lvl0_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_kind_o == ACK_MASK) |-> $past(svc_q) != 3'd0);
  p_strict_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_kind_o == ACK_MASK && $past(svc_q) < SVC_NMI) |->
      (({1'b0, ack_lvl_o} < $past(svc_q)) ||
       (ack_lvl_o == 2'd3 && $past(svc_q) == 3'd3 && !$past(lock3_i))));
  p_macro_keeps_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_kind_o == ACK_MACRO) |-> svc_q == $past(svc_q));
  p_nmi_not_nested_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && ack_kind_o == ACK_NMI) |-> $past(svc_q) != SVC_NMI);
endmodule

// File: tb/nest_irq_arbiter_test.sv
module nest_irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0, mac = '0;
  logic [31:0] lvl;
  logic        nmi = 1'b0, ei = 1'b0, lock3 = 1'b1, eos = 1'b0;
  logic        ack_valid;
  logic [1:0]  ack_kind, ack_lvl;
  logic [3:0]  ack_src;
  logic [2:0]  svc;

  int    n_chk = 0, n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  nest_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_i(lvl), .macro_i(mac),
    .nmi_i(nmi), .ei_i(ei), .lock3_i(lock3), .eos_i(eos),
    .ack_valid_o(ack_valid), .ack_kind_o(ack_kind), .ack_src_o(ack_src),
    .ack_lvl_o(ack_lvl), .svc_lvl_o(svc));

  function automatic logic [1:0] lvl_of(int i);
    case (i)
      1, 4:          return 2'd0;
      2, 3, 9, 12:   return 2'd1;
      5, 6, 10:      return 2'd2;
      default:       return 2'd3;
    endcase
  endfunction

  initial for (int i = 0; i < 16; i++) lvl[2*i +: 2] = lvl_of(i);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ack(logic [1:0] k, logic [3:0] s, logic [1:0] l, string t);
    exp_q.push_back({k, s, l});
    tag_q.push_back(t);
  endtask

  task automatic pulse_req(logic [15:0] v);
    req = v; step(); req = '0; step(3);
  endtask
  task automatic pulse_ei();  ei = 1'b1;  step(); ei = 1'b0;  step(3); endtask
  task automatic pulse_eos(); eos = 1'b1; step(); eos = 1'b0; step(3); endtask
  task automatic pulse_nmi(); nmi = 1'b1; step(); nmi = 1'b0; step(3); endtask
  task automatic pulse_mac(logic [15:0] v);
    mac = v; step(); mac = '0; step(3);
  endtask

  task automatic check_svc(logic [2:0] e, string t);
    n_chk++;
    if (svc !== e) begin
      n_fail++;
      $display("FAIL %s: in-service code %0d, expected %0d", t, svc, e);
    end
  endtask

  // Monitor: every acknowledge must match the next expected item in order.
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected ack: kind %0d src %0d lvl %0d, expected none",
                 ack_kind, ack_src, ack_lvl);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({ack_kind, ack_src, ack_lvl} !== e) begin
          n_fail++;
          $display("FAIL %s: ack kind %0d src %0d lvl %0d, expected kind %0d src %0d lvl %0d",
                   t, ack_kind, ack_src, ack_lvl, e[7:6], e[5:2], e[1:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1: reset state
    n_chk++;
    if (ack_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: ack_valid %0b, expected 0", ack_valid);
    end
    check_svc(3'd7, "R1");

    // R2: no grant with enable clear; enable pulse releases it
    pulse_req(16'h0020);
    check_svc(3'd7, "R2");
    expect_ack(2'd0, 4'd5, 2'd2, "R3");
    pulse_ei();
    check_svc(3'd2, "R3");

    // R4: equal and lower-urgency levels are held; a more urgent one preempts
    pulse_ei();
    pulse_req(16'h0040);
    pulse_req(16'h0080);
    check_svc(3'd2, "R4");
    expect_ack(2'd0, 4'd2, 2'd1, "R4");
    pulse_req(16'h0004);
    check_svc(3'd1, "R4");

    // R10: unwind; pending granted by level then index
    pulse_eos();
    check_svc(3'd2, "R10");
    pulse_eos();
    check_svc(3'd7, "R10");
    expect_ack(2'd0, 4'd6, 2'd2, "R10");
    pulse_ei();
    pulse_ei();
    check_svc(3'd2, "R10");
    expect_ack(2'd0, 4'd7, 2'd3, "R10");
    pulse_eos();
    check_svc(3'd3, "R10");
    pulse_eos();
    check_svc(3'd7, "R10");

    // R7: arrival order does not matter, lowest index wins among equal levels
    pulse_req(16'h0200);
    pulse_req(16'h1008);
    expect_ack(2'd0, 4'd3, 2'd1, "R7");
    pulse_ei();
    pulse_eos();
    expect_ack(2'd0, 4'd9, 2'd1, "R7");
    pulse_ei();
    pulse_eos();
    expect_ack(2'd0, 4'd12, 2'd1, "R7");
    pulse_ei();
    pulse_eos();
    check_svc(3'd7, "R7");

    // R5: level-0 service blocks all maskable requests
    expect_ack(2'd0, 4'd4, 2'd0, "R5");
    pulse_ei();
    pulse_req(16'h0010);
    pulse_ei();
    pulse_req(16'h0102);
    check_svc(3'd0, "R5");
    // R8: macro service still acknowledged, no nesting change
    expect_ack(2'd1, 4'd10, 2'd0, "R8");
    pulse_mac(16'h0400);
    check_svc(3'd0, "R8");
    // R9: non-maskable nests beyond level 0
    expect_ack(2'd2, 4'd0, 2'd0, "R9");
    pulse_nmi();
    check_svc(3'd4, "R9");
    pulse_eos();
    check_svc(3'd0, "R10");
    expect_ack(2'd0, 4'd1, 2'd0, "R10");
    pulse_eos();
    check_svc(3'd0, "R10");
    pulse_ei();
    expect_ack(2'd0, 4'd8, 2'd3, "R10");
    pulse_eos();
    check_svc(3'd3, "R10");

    // R6: level 3 under level 3 follows the lock input
    pulse_ei();
    pulse_req(16'h0800);
    check_svc(3'd3, "R6");
    expect_ack(2'd0, 4'd11, 2'd3, "R6");
    lock3 = 1'b0;
    step(4);
    for (int k = 0; k < 4; k++) begin
      logic [3:0] s;
      s = (k == 3) ? 4'd0 : 4'(13 + k);
      pulse_ei();
      expect_ack(2'd0, s, 2'd3, "R6");
      pulse_req(16'(1) << s);
    end

    // R11: full stack blocks maskable and non-maskable grants
    pulse_ei();
    pulse_req(16'h0080);
    pulse_nmi();
    check_svc(3'd3, "R11");
    // R9: after one pop the non-maskable request wins over the maskable one
    expect_ack(2'd2, 4'd0, 2'd0, "R9");
    pulse_eos();
    check_svc(3'd4, "R9");
    expect_ack(2'd0, 4'd7, 2'd3, "R11");
    pulse_eos();
    check_svc(3'd3, "R11");
    for (int k = 0; k < 6; k++) pulse_eos();
    check_svc(3'd7, "R10");

    step(4);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: %0d acknowledges missing, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule